// File: doc/BRIEF.md
# Serial Memory-Access Bridge

This block is a 32-bit SPI slave that lets an external master reach the internal state of a neural processor. Each frame opens with a 32-bit command word. That word carries the transfer direction, a 3-bit target code, a transfer count and a 16-bit starting index. One or more 32-bit data fields follow it. Each data field becomes one access on a generic request port. The targets are write-only configuration registers, a neuron state memory, an output-neuron register file and three weight memories. The memories sit outside the block, on the far side of the request port.

SCK and MOSI are oversampled in the system clock domain, so SCK must run at least four times slower than the system clock. There is no chip select. The bit counter returns to zero on reset and at the end of every frame. For a burst, the bridge adds one to the 16-bit index after each field. The two low index bits choose a 32-bit chunk of a 128-bit word, so the chunk wraps into the next word. A local access-enable flag, held at configuration index 0, gates every target except the configuration registers. The bridge reports readiness when that flag is set and the core says it is frozen.

Top module: `spi_mem_bridge`

## Requirements
- R1: SPI mode 0, MSB first. MOSI is taken on rising SCK. Command bit 31 selects read (1) or write (0). Bits 30:28 select the target: 0 config, 1 neuron memory, 2 output-neuron potentials, 3 input weights, 4 recurrent weights, 5 output weights. Bits 15:0 give the starting index.
- R2: After the 32nd bit of a write data field, `req_valid` pulses for one cycle with `req_write`=1. The pulse carries the target code, `req_word` = index[15:2], `req_chunk` = index[1:0] and `req_wdata` = the field.
- R3: Command bits 27:16 give the number of data fields. A count of 0 acts as 1. Field k uses the starting index plus k, and the increment carries from the chunk bits into the word bits.
- R4: A read request is issued on the last bit of the command word, and on the last bit of each field except the final one. `rd_data` is taken one cycle after `req_valid` and shifted out MSB first on MISO. MISO changes on falling SCK, so each bit is valid before the rising edge of its field bit.
- R5: A read of target 0 issues no request, and every field shifts out as zero.
- R6: Bit 0 of a write to config index 0 sets the access-enable flag, which resets to 1. While the flag is 0, targets 1 to 5 issue no request and their reads return zero. Config writes are always forwarded.
- R7: Index bits above each target's range are forced to zero on the request. Usable index bits per target: config 16, neuron 9, output-neuron 4, input and recurrent weights 14, output weights 11.
- R8: `spi_ready` equals access-enable AND `core_frozen`, registered one cycle.
- R9: Target codes 6 and 7 issue no request, and their reads return zero.
- R10: After reset: `miso`=0, `req_valid`=0, `access_en`=1, `spi_ready`=0.
- R11: MISO is driven low on every falling SCK outside the data fields of a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI clock from master |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| core_frozen | input | 1 | Core sits in its frozen configuration state |
| access_en | output | 1 | Access-enable flag (config index 0) |
| spi_ready | output | 1 | Internal state may be accessed |
| req_valid | output | 1 | One-cycle request strobe |
| req_write | output | 1 | 1 for write, 0 for read |
| req_target | output | 3 | Target code |
| req_word | output | 14 | Word index (masked per target) |
| req_chunk | output | 2 | 32-bit chunk within the 128-bit word |
| req_wdata | output | 32 | Write data |
| rd_data | input | 32 | Read data, valid the cycle after a read request |

## Verification
The bench runs read bursts whose first read is issued only a few system cycles before the first falling SCK. A bridge that issued that read late, or lost the capture when the load and the first shift fall in the same cycle, would shift out a stale or zero MSB. Bursts start at chunk 3 so the index carry into the word field is exercised; a wrong increment would send a repeated or skipped chunk. Config reads, codes 6 and 7, and memory accesses while the enable flag is cleared all check that the request port stays silent and MISO returns zeros; a leaky gate shows up as extra logged requests or non-zero read data. Per-target index masking and a count of zero are covered both by directed frames and by about forty random frames.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 16;
  localparam int CNT_W   = 12;
  localparam int CODE_W  = 3;
  localparam int WORD_W  = ADDR_W - 2;

  localparam int RW_BIT  = FRAME_W - 1;
  localparam int CODE_HI = FRAME_W - 2;
  localparam int CODE_LO = FRAME_W - 1 - CODE_W;
  localparam int CNT_HI  = CODE_LO - 1;
  localparam int CNT_LO  = ADDR_W;

  localparam logic [CODE_W-1:0] TGT_CFG   = 3'd0;
  localparam logic [CODE_W-1:0] TGT_NEUR  = 3'd1;
  localparam logic [CODE_W-1:0] TGT_ONEUR = 3'd2;
  localparam logic [CODE_W-1:0] TGT_WIN   = 3'd3;
  localparam logic [CODE_W-1:0] TGT_WREC  = 3'd4;
  localparam logic [CODE_W-1:0] TGT_WOUT  = 3'd5;

  // usable index bits (word plus chunk) per target
  localparam int NEUR_IW  = 9;
  localparam int ONEUR_IW = 4;
  localparam int WIN_IW   = 14;
  localparam int WREC_IW  = 14;
  localparam int WOUT_IW  = 11;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  function automatic logic [ADDR_W-1:0] idx_mask(input logic [CODE_W-1:0] code);
    int w;
    logic [ADDR_W:0] full;
    case (code)
      TGT_NEUR:  w = NEUR_IW;
      TGT_ONEUR: w = ONEUR_IW;
      TGT_WIN:   w = WIN_IW;
      TGT_WREC:  w = WREC_IW;
      TGT_WOUT:  w = WOUT_IW;
      default:   w = ADDR_W;
    endcase
    full = ((ADDR_W+1)'(1) << w) - (ADDR_W+1)'(1);
    return full[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] mosi_pipe;
  logic              sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_pipe  <= '0;
      mosi_pipe <= '0;
      sck_prev  <= 1'b0;
    end else begin
      sck_pipe  <= {sck_pipe[STAGES-2:0], sck};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi};
      sck_prev  <= sck_pipe[STAGES-1];
    end
  end

  assign sck_rise = sck_pipe[STAGES-1] & ~sck_prev;
  assign sck_fall = ~sck_pipe[STAGES-1] & sck_prev;
  assign mosi_s   = mosi_pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_rise,
  input  logic               mosi_s,
  output logic               req_valid,
  output logic               req_write,
  output logic [CODE_W-1:0]  req_target,
  output logic [WORD_W-1:0]  req_word,
  output logic [1:0]         req_chunk,
  output logic [FRAME_W-1:0] req_wdata,
  output logic               access_en,
  output logic               zero_load,
  output logic               rd_phase
);
  localparam int BC_W = $clog2(FRAME_W);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(FRAME_W - 1);

  phase_e             phase;
  logic [BC_W-1:0]    bit_cnt;
  logic [FRAME_W-1:0] rx_sh;
  logic [FRAME_W-1:0] rx_word;
  logic               rd_q;
  logic [CODE_W-1:0]  code_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   left_q;
  logic               field_done;

  logic               iss, iss_wr, allowed;
  logic [CODE_W-1:0]  iss_code;
  logic [ADDR_W-1:0]  iss_addr, nxt_addr, iss_masked;
  logic [CNT_W-1:0]   cmd_cnt;

  assign rx_word    = {rx_sh[FRAME_W-2:0], mosi_s};
  assign field_done = sck_rise && (bit_cnt == BIT_LAST);
  assign nxt_addr   = addr_q + ADDR_W'(1);
  assign cmd_cnt    = rx_word[CNT_HI:CNT_LO];
  assign rd_phase   = (phase == PH_DATA) && rd_q;

  always_comb begin
    iss      = 1'b0;
    iss_wr   = 1'b0;
    iss_code = code_q;
    iss_addr = addr_q;
    if (field_done) begin
      if (phase == PH_CMD) begin
        if (rx_word[RW_BIT]) begin
          iss      = 1'b1;
          iss_code = rx_word[CODE_HI:CODE_LO];
          iss_addr = rx_word[ADDR_W-1:0];
        end
      end else if (!rd_q) begin
        iss    = 1'b1;
        iss_wr = 1'b1;
      end else if (left_q != CNT_W'(1)) begin
        iss      = 1'b1;
        iss_addr = nxt_addr;
      end
    end
    if (iss_code == TGT_CFG) allowed = iss_wr;
    else                     allowed = (iss_code <= TGT_WOUT) && access_en;
    iss_masked = iss_addr & idx_mask(iss_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_CMD;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      rd_q       <= 1'b0;
      code_q     <= '0;
      addr_q     <= '0;
      left_q     <= '0;
      req_valid  <= 1'b0;
      req_write  <= 1'b0;
      req_target <= '0;
      req_word   <= '0;
      req_chunk  <= '0;
      req_wdata  <= '0;
      access_en  <= 1'b1;
      zero_load  <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      zero_load <= 1'b0;
      if (iss && allowed) begin
        req_valid  <= 1'b1;
        req_write  <= iss_wr;
        req_target <= iss_code;
        req_word   <= iss_masked[ADDR_W-1:2];
        req_chunk  <= iss_masked[1:0];
        req_wdata  <= iss_wr ? rx_word : '0;
      end
      if (iss && !allowed && !iss_wr) zero_load <= 1'b1;
      if (iss && iss_wr && iss_code == TGT_CFG && iss_addr == '0)
        access_en <= rx_word[0];

      if (sck_rise) begin
        rx_sh   <= rx_word;
        bit_cnt <= field_done ? '0 : bit_cnt + BC_W'(1);
      end
      if (field_done) begin
        if (phase == PH_CMD) begin
          rd_q   <= rx_word[RW_BIT];
          code_q <= rx_word[CODE_HI:CODE_LO];
          addr_q <= rx_word[ADDR_W-1:0];
          left_q <= (cmd_cnt == '0) ? CNT_W'(1) : cmd_cnt;
          phase  <= PH_DATA;
        end else begin
          addr_q <= nxt_addr;
          if (left_q == CNT_W'(1)) phase <= PH_CMD;
          else                     left_q <= left_q - CNT_W'(1);
        end
      end
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
  // R5
  cfg_noread_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !(req_target == TGT_CFG && !req_write));
  // R6
  mem_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target != TGT_CFG) |-> access_en);
  // R9
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_target <= TGT_WOUT));
  // R7
  neur_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target == TGT_NEUR) |-> (req_word[WORD_W-1:NEUR_IW-2] == '0));
  // R7
  oneur_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target == TGT_ONEUR) |-> (req_word[WORD_W-1:ONEUR_IW-2] == '0));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_fall,
  input  logic               rd_phase,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               zero_load,
  input  logic [FRAME_W-1:0] rd_data,
  output logic               miso
);
  logic [FRAME_W-1:0] tx_reg;
  logic [FRAME_W-1:0] cur;
  logic               rd_pend;

  // read data arriving in the same cycle as a shift is used directly
  assign cur = rd_pend ? rd_data : tx_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_reg  <= '0;
      rd_pend <= 1'b0;
      miso    <= 1'b0;
    end else begin
      rd_pend <= req_valid && !req_write;
      if (zero_load) begin
        tx_reg <= '0;
      end else if (sck_fall && rd_phase) begin
        miso   <= cur[FRAME_W-1];
        tx_reg <= {cur[FRAME_W-2:0], 1'b0};
      end else if (rd_pend) begin
        tx_reg <= rd_data;
      end
      if (sck_fall && !rd_phase) miso <= 1'b0;
    end
  end

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sck_fall && !rd_phase) |=> !miso);
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pend |-> !(req_valid && !req_write));
endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge
  import spi_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck,
  input  logic               mosi,
  output logic               miso,
  input  logic               core_frozen,
  output logic               access_en,
  output logic               spi_ready,
  output logic               req_valid,
  output logic               req_write,
  output logic [CODE_W-1:0]  req_target,
  output logic [WORD_W-1:0]  req_word,
  output logic [1:0]         req_chunk,
  output logic [FRAME_W-1:0] req_wdata,
  input  logic [FRAME_W-1:0] rd_data
);
  logic sck_rise, sck_fall, mosi_s, zero_load, rd_phase;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  spi_frame_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .mosi_s(mosi_s),
    .req_valid(req_valid), .req_write(req_write), .req_target(req_target),
    .req_word(req_word), .req_chunk(req_chunk), .req_wdata(req_wdata),
    .access_en(access_en), .zero_load(zero_load), .rd_phase(rd_phase)
  );

  spi_tx_shift u_tx (
    .clk(clk), .rst(rst), .sck_fall(sck_fall), .rd_phase(rd_phase),
    .req_valid(req_valid), .req_write(req_write), .zero_load(zero_load),
    .rd_data(rd_data), .miso(miso)
  );

  always_ff @(posedge clk) begin
    if (rst) spi_ready <= 1'b0;
    else     spi_ready <= access_en && core_frozen;
  end

  // R8
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_ready) |-> $past(access_en));
endmodule

// File: tb/tb_spi_mem_bridge.sv
module tb_spi_mem_bridge;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic        miso;
  logic        core_frozen = 1'b0;
  logic        access_en, spi_ready;
  logic        req_valid, req_write;
  logic [2:0]  req_target;
  logic [13:0] req_word;
  logic [1:0]  req_chunk;
  logic [31:0] req_wdata;
  logic [31:0] rd_data = '0;

  int ntot = 0;
  int nbad = 0;
  bit en_model = 1'b1;

  logic [31:0] wbuf [0:7];
  logic [31:0] rbuf [0:7];

  int          lg_n = 0;
  logic [2:0]  lg_tgt   [0:255];
  logic [13:0] lg_word  [0:255];
  logic [1:0]  lg_chunk [0:255];
  logic        lg_wr    [0:255];
  logic [31:0] lg_data  [0:255];

  always #4 clk = ~clk;

  spi_mem_bridge dut (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .miso(miso),
    .core_frozen(core_frozen), .access_en(access_en), .spi_ready(spi_ready),
    .req_valid(req_valid), .req_write(req_write), .req_target(req_target),
    .req_word(req_word), .req_chunk(req_chunk), .req_wdata(req_wdata),
    .rd_data(rd_data)
  );

  function automatic logic [31:0] mem_val(input logic [2:0] t, input logic [13:0] w,
                                          input logic [1:0] c);
    return {t, w, c, 13'h15A} ^ 32'h5A5A_3C3C;
  endfunction

  function automatic logic [15:0] exp_mask(input logic [2:0] code);
    case (code)
      3'd1:       return 16'h01FF;
      3'd2:       return 16'h000F;
      3'd3, 3'd4: return 16'h3FFF;
      3'd5:       return 16'h07FF;
      default:    return 16'hFFFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (req_valid && !req_write) rd_data <= mem_val(req_target, req_word, req_chunk);
    if (req_valid) begin
      lg_tgt[lg_n % 256]   <= req_target;
      lg_word[lg_n % 256]  <= req_word;
      lg_chunk[lg_n % 256] <= req_chunk;
      lg_wr[lg_n % 256]    <= req_write;
      lg_data[lg_n % 256]  <= req_wdata;
      lg_n <= lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic shift_word(input logic [31:0] tx, output logic [31:0] rx);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk) mosi = tx[i];
      repeat (HALF - 1) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  // run a frame and check requests and read data against the model
  task automatic frame(input logic rw, input logic [2:0] code, input logic [11:0] cnt,
                       input logic [15:0] addr, input string tag);
    logic [31:0] dummy;
    int n, base, got;
    bit allowed;
    logic [15:0] a;
    n = (cnt == 0) ? 1 : int'(cnt);
    base = lg_n;
    shift_word({rw, code, cnt, addr}, dummy);
    for (int f = 0; f < n; f++) begin
      logic [31:0] r;
      shift_word(rw ? 32'h0 : wbuf[f], r);
      rbuf[f] = r;
    end
    repeat (12) @(negedge clk);
    allowed = (code == 3'd0) ? !rw : (code <= 3'd5 && en_model);
    got = lg_n - base;
    chk(got == (allowed ? n : 0), {tag, " request count"}, got, allowed ? n : 0);
    for (int f = 0; f < n; f++) begin
      a = (addr + 16'(f)) & exp_mask(code);
      if (allowed && got == n) begin
        int k;
        k = (base + f) % 256;
        chk(lg_tgt[k] == code && lg_wr[k] == !rw, {tag, " target/dir"},
            {28'(lg_tgt[k]), 3'b0, lg_wr[k]}, {28'(code), 3'b0, !rw});
        chk({lg_word[k], lg_chunk[k]} == a, {tag, " index"},
            {16'h0, lg_word[k], lg_chunk[k]}, {16'h0, a});
        if (!rw) chk(lg_data[k] == wbuf[f], {tag, " wdata"}, lg_data[k], wbuf[f]);
      end
      if (rw) chk(rbuf[f] == (allowed ? mem_val(code, a[15:2], a[1:0]) : 32'h0),
                  {tag, " miso data"}, rbuf[f],
                  allowed ? mem_val(code, a[15:2], a[1:0]) : 32'h0);
    end
    if (!rw && code == 3'd0 && addr == 16'h0) en_model = wbuf[0][0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    ntot++; nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    logic [31:0] seedv;
    seedv = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk(miso == 1'b0, "R10 miso", miso, 0);
    chk(req_valid == 1'b0, "R10 req_valid", req_valid, 0);
    chk(access_en == 1'b1, "R10 access_en", access_en, 1);
    chk(spi_ready == 1'b0, "R10 spi_ready", spi_ready, 0);

    // R8 ready follows enable and frozen
    core_frozen = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_ready == 1'b1, "R8 ready set", spi_ready, 1);

    // R1 R2 single write to neuron memory
    wbuf[0] = 32'hDEAD_BEEF;
    frame(1'b0, 3'd1, 12'd1, 16'h0123, "R1 R2 neuron write");
    // R11 MISO low after a write frame
    chk(miso == 1'b0, "R11 miso idle", miso, 0);
    // R3 burst crossing a chunk boundary
    wbuf[0] = 32'h1111_0001; wbuf[1] = 32'h2222_0002; wbuf[2] = 32'h3333_0003;
    frame(1'b0, 3'd3, 12'd3, 16'h0A03, "R3 win burst write");
    // R3 count zero acts as one
    wbuf[0] = 32'h0BAD_F00D;
    frame(1'b0, 3'd4, 12'd0, 16'h0042, "R3 count zero");
    // R4 single read and burst read
    frame(1'b1, 3'd1, 12'd1, 16'h0057, "R4 neuron read");
    frame(1'b1, 3'd5, 12'd4, 16'h02FE, "R4 wout burst read");
    // R7 upper index bits masked
    wbuf[0] = 32'hCAFE_0001;
    frame(1'b0, 3'd2, 12'd1, 16'hFFF7, "R7 oneur mask");
    frame(1'b1, 3'd5, 12'd2, 16'hF9FF, "R7 wout mask");
    // R5 config read returns zero, no request
    frame(1'b1, 3'd0, 12'd2, 16'h0005, "R5 cfg read");
    wbuf[0] = 32'h0000_00A5;
    frame(1'b0, 3'd0, 12'd1, 16'h0005, "R6 cfg write");
    // R9 invalid codes
    wbuf[0] = 32'h1234_5678;
    frame(1'b0, 3'd6, 12'd1, 16'h0001, "R9 code6 write");
    frame(1'b1, 3'd7, 12'd1, 16'h0001, "R9 code7 read");
    // R6 clear access enable
    wbuf[0] = 32'h0;
    frame(1'b0, 3'd0, 12'd1, 16'h0000, "R6 disable");
    chk(access_en == 1'b0, "R6 access_en cleared", access_en, 0);
    chk(spi_ready == 1'b0, "R8 ready cleared", spi_ready, 0);
    wbuf[0] = 32'h7777_7777;
    frame(1'b0, 3'd3, 12'd1, 16'h0010, "R6 gated write");
    frame(1'b1, 3'd1, 12'd2, 16'h0010, "R6 gated read");
    wbuf[0] = 32'h1;
    frame(1'b0, 3'd0, 12'd1, 16'h0000, "R6 enable");
    chk(access_en == 1'b1, "R6 access_en set", access_en, 1);
    chk(spi_ready == 1'b1, "R8 ready again", spi_ready, 1);

    // random frames
    for (int i = 0; i < 40; i++) begin
      logic        rw;
      logic [2:0]  code;
      logic [11:0] cnt;
      logic [15:0] addr;
      rw   = 1'($urandom);
      code = 3'($urandom % 8);
      cnt  = 12'($urandom % 4);
      addr = 16'($urandom);
      if (code == 3'd0) addr = 16'h0010 + 16'($urandom % 512);
      for (int f = 0; f < 8; f++) wbuf[f] = $urandom;
      frame(rw, code, cnt, addr, "R1 R2 R3 R4 R7 random");
    end

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule